// File: doc/BRIEF.md
# Burst Header Receiver with Tap-Select Phase Alignment

This block recovers a short serial header that arrives in bursts, one header per fixed slot, while all of its logic runs at one clock per bit. An external delay line presents several copies of the incoming line, each lagging the previous one by an equal fraction of a bit. The block samples every copy on every clock edge. During a short alternating preamble at the start of each slot, it finds where the data edge falls within the tap vector. It ignores extra edges that bounce above the first one and averages the edge position over the preamble bits with modulo wrap. It then locks onto the tap half a bit away from that average.

Once locked, the block shifts the header bits in from the chosen tap, most significant bit first. At the end of the header it presents the word with a one-cycle valid pulse and an address-match pulse when the upper byte equals the local node address. A slot-start strobe restarts acquisition at any time. If no edge is seen during the preamble, the previous tap is kept and that slot's header is not marked valid.

Top module: `phase_align_rx`

## Requirements
- R1: After reset, selTap is 0, hdrWord is 0, and hdrValid and addrMatch are low.
- R2: During each preamble cycle the edge position is the lowest index i for which tapIn[i] differs from tapIn[i+1], with i in 0..NUM_TAPS-2. Further differences at higher indices in the same vector are ignored. A vector with no difference gives no edge.
- R3: The averaged position is (ref + floor(S/4)) mod 8. Here ref is the first edge seen in the preamble. S is the sum over later edges of (pos - ref) mod 8, each read as a signed value in -4..3. Preamble cycles without an edge add 0.
- R4: selTap becomes (average + 4) mod 8 in the cycle after the fourth preamble cycle. The first preamble cycle is the one in which slotStart is high. selTap changes at no other time.
- R5: If no preamble cycle shows an edge, selTap keeps its previous value and that slot gives neither hdrValid nor addrMatch.
- R6: The header consists of the 16 bits after the 4 preamble bits (preamble pattern 1,0,1,0), sent MSB first. If selTap is above the averaged position, the chosen tap shows the previous bit and is read live. Otherwise it is read from the vector one cycle earlier. hdrWord is loaded and hdrValid pulses high for one cycle, 21 cycles after the slotStart cycle.
- R7: addrMatch is high exactly in the hdrValid cycle in which hdrWord[15:8] equals nodeAddr.
- R8: A slotStart during a header in progress abandons it: no hdrValid follows for the abandoned header, and the new slot is acquired normally.
- R9: After hdrValid, changes on tapIn do not alter hdrWord or raise hdrValid until the next slot completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| tapIn | input | NUM_TAPS | Delay-line copies of the line, index 0 least delayed |
| slotStart | input | 1 | High in the cycle of the first preamble bit |
| nodeAddr | input | ADDR_BITS | Local node address |
| selTap | output | TAP_W | Currently locked tap index |
| hdrWord | output | HDR_BITS | Last captured header |
| hdrValid | output | 1 | One-cycle pulse when a reliable header is captured |
| addrMatch | output | 1 | Pulse with hdrValid when the address byte matches |

## Verification
On every cycle the assertions check that the tap only moves right after a preamble ends, that hdrValid is a single-cycle pulse, and that addrMatch agrees with the captured address byte. The values themselves can only be shown by the bench's scenarios. These are the averaged tap under swept base phases, jitter, bounce and wrap across the tap range, the recovered word under both live and delayed reading, the no-edge fallback, and the abandoned header.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef struct packed {
    logic preOn;     // a preamble vector is on tapIn
    logic preFirst;  // first preamble vector of the slot
    logic preLast;   // last preamble vector, lock the tap now
    logic hdrShift;  // shift one header bit in
    logic hdrDone;   // final header bit, present the word
  } ctlStrobes_t;
endpackage

// File: rtl/pa_ctrl.sv
module pa_ctrl
  import pa_pkg::*;
#(
  parameter int PRE_BITS = 4,
  parameter int HDR_BITS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        slotStart,
  output ctlStrobes_t strb
);
  localparam int PC_W = $clog2(PRE_BITS + 1);
  localparam int HC_W = $clog2(HDR_BITS + 1);

  logic            preActive;
  logic [PC_W-1:0] preCnt;
  logic [PC_W-1:0] preIdx;
  logic            hdrActive;
  logic [HC_W-1:0] hdrCnt;

  always_comb begin
    preIdx        = slotStart ? '0 : preCnt;
    strb.preOn    = slotStart | preActive;
    strb.preFirst = slotStart;
    strb.preLast  = strb.preOn && (preIdx == PC_W'(PRE_BITS - 1));
    // first header cycle only reads the preamble tail, so no shift there
    strb.hdrShift = hdrActive && (hdrCnt != '0);
    strb.hdrDone  = hdrActive && (hdrCnt == HC_W'(HDR_BITS));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preActive <= 1'b0;
      preCnt    <= '0;
      hdrActive <= 1'b0;
      hdrCnt    <= '0;
    end else begin
      if (strb.preLast) begin
        preActive <= 1'b0;
        preCnt    <= '0;
      end else if (strb.preOn) begin
        preActive <= 1'b1;
        preCnt    <= preIdx + 1'b1;
      end
      if (strb.preLast) begin
        hdrActive <= 1'b1;
        hdrCnt    <= '0;
      end else if (slotStart || strb.hdrDone) begin
        hdrActive <= 1'b0;
      end else if (hdrActive) begin
        hdrCnt <= hdrCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pa_datapath.sv
module pa_datapath
  import pa_pkg::*;
#(
  parameter int NUM_TAPS  = 8,
  parameter int PRE_BITS  = 4,
  parameter int HDR_BITS  = 16,
  parameter int ADDR_BITS = 8,
  localparam int TAP_W    = $clog2(NUM_TAPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strb,
  input  logic [NUM_TAPS-1:0]  tapIn,
  input  logic [ADDR_BITS-1:0] nodeAddr,
  output logic [TAP_W-1:0]     selTap,
  output logic [HDR_BITS-1:0]  hdrWord,
  output logic                 hdrValid,
  output logic                 addrMatch
);
  localparam int AVG_SH = $clog2(PRE_BITS);
  localparam int SUM_W  = TAP_W + AVG_SH + 1;

  // adjacent-tap differences
  logic [NUM_TAPS-2:0] diffVec;
  for (genvar g = 0; g < NUM_TAPS - 1; g++) begin : g_diff
    assign diffVec[g] = tapIn[g] ^ tapIn[g+1];
  end

  logic                    edgeFound;
  logic [TAP_W-1:0]        edgePos;
  logic [TAP_W-1:0]        refPos, nextRef, rawDiff, avgPos, newSel;
  logic                    haveRef, curHave, nextHave;
  logic signed [SUM_W-1:0] sumAcc, curSum, stepDiff, nextSum, avgOff;
  logic                    useLive, lockOk, pickBit;
  logic [NUM_TAPS-1:0]     prevTaps;
  logic [HDR_BITS-2:0]     shiftReg;
  logic [HDR_BITS-1:0]     shiftNext;

  // lowest differing pair wins; higher ones are bounce
  always_comb begin
    edgeFound = |diffVec;
    edgePos   = '0;
    for (int i = NUM_TAPS - 2; i >= 0; i--)
      if (diffVec[i]) edgePos = TAP_W'(i);
  end

  always_comb begin
    curHave  = strb.preFirst ? 1'b0 : haveRef;
    curSum   = strb.preFirst ? '0 : sumAcc;
    rawDiff  = edgePos - refPos;
    stepDiff = (edgeFound && curHave)
             ? {{(SUM_W - TAP_W){rawDiff[TAP_W-1]}}, rawDiff} : '0;
    nextRef  = curHave ? refPos : edgePos;
    nextHave = curHave | edgeFound;
    nextSum  = curSum + stepDiff;
    avgOff   = nextSum >>> AVG_SH;
    avgPos   = TAP_W'(avgOff + SUM_W'(nextRef));
    newSel   = avgPos + TAP_W'(NUM_TAPS / 2);
    pickBit  = useLive ? tapIn[selTap] : prevTaps[selTap];
    shiftNext = {shiftReg, pickBit};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPos    <= '0;
      haveRef   <= 1'b0;
      sumAcc    <= '0;
      selTap    <= '0;
      useLive   <= 1'b0;
      lockOk    <= 1'b0;
      prevTaps  <= '0;
      shiftReg  <= '0;
      hdrWord   <= '0;
      hdrValid  <= 1'b0;
      addrMatch <= 1'b0;
    end else begin
      prevTaps <= tapIn;
      if (strb.preOn) begin
        refPos  <= nextRef;
        haveRef <= nextHave;
        sumAcc  <= nextSum;
      end
      if (strb.preLast) begin
        lockOk <= nextHave;
        if (nextHave) begin
          selTap  <= newSel;
          useLive <= newSel > avgPos;
        end
      end
      if (strb.hdrShift) shiftReg <= shiftNext[HDR_BITS-2:0];
      if (strb.hdrDone) begin
        hdrWord   <= shiftNext;
        hdrValid  <= lockOk;
        addrMatch <= lockOk && (shiftNext[HDR_BITS-1 -: ADDR_BITS] == nodeAddr);
      end else begin
        hdrValid  <= 1'b0;
        addrMatch <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/phase_align_rx.sv
module phase_align_rx
  import pa_pkg::*;
#(
  parameter int NUM_TAPS  = 8,
  parameter int PRE_BITS  = 4,
  parameter int HDR_BITS  = 16,
  parameter int ADDR_BITS = 8,
  localparam int TAP_W    = $clog2(NUM_TAPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_TAPS-1:0]  tapIn,
  input  logic                 slotStart,
  input  logic [ADDR_BITS-1:0] nodeAddr,
  output logic [TAP_W-1:0]     selTap,
  output logic [HDR_BITS-1:0]  hdrWord,
  output logic                 hdrValid,
  output logic                 addrMatch
);
  ctlStrobes_t strb;

  pa_ctrl #(.PRE_BITS(PRE_BITS), .HDR_BITS(HDR_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .slotStart(slotStart), .strb(strb)
  );

  pa_datapath #(
    .NUM_TAPS(NUM_TAPS), .PRE_BITS(PRE_BITS),
    .HDR_BITS(HDR_BITS), .ADDR_BITS(ADDR_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tapIn(tapIn), .nodeAddr(nodeAddr),
    .selTap(selTap), .hdrWord(hdrWord), .hdrValid(hdrValid), .addrMatch(addrMatch)
  );
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
  parameter int TAP_W     = 3,
  parameter int PRE_BITS  = 4,
  parameter int HDR_BITS  = 16,
  parameter int ADDR_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 slotStart,
  input logic [ADDR_BITS-1:0] nodeAddr,
  input logic [TAP_W-1:0]     selTap,
  input logic [HDR_BITS-1:0]  hdrWord,
  input logic                 hdrValid,
  input logic                 addrMatch
);
  logic [5:0] startCnt;
  logic       preEnd;

  always_ff @(posedge clk) begin
    if (!rstN) startCnt <= '0;
    else if (slotStart) startCnt <= 6'd1;
    else if (startCnt != '0 && startCnt != 6'd63) startCnt <= startCnt + 6'd1;
  end

  assign preEnd = (PRE_BITS == 1) ? slotStart
                : (!slotStart && startCnt == 6'(PRE_BITS - 1));

  p_tap_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    !preEnd |=> $stable(selTap));

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |=> !hdrValid);

  p_match_needs_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    addrMatch |-> hdrValid);

  p_match_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |-> (addrMatch == (hdrWord[HDR_BITS-1 -: ADDR_BITS] == $past(nodeAddr))));
endmodule

bind phase_align_rx pa_checker #(
  .TAP_W(TAP_W), .PRE_BITS(PRE_BITS), .HDR_BITS(HDR_BITS), .ADDR_BITS(ADDR_BITS)
) u_chk (
  .clk(clk), .rstN(rstN), .slotStart(slotStart), .nodeAddr(nodeAddr),
  .selTap(selTap), .hdrWord(hdrWord), .hdrValid(hdrValid), .addrMatch(addrMatch)
);

// File: tb/test_phase_align_rx.sv
module test_phase_align_rx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  tapIn = '0;
  logic        slotStart = 1'b0;
  logic [7:0]  nodeAddr = 8'hC3;
  logic [2:0]  selTap;
  logic [15:0] hdrWord;
  logic        hdrValid, addrMatch;

  int checks = 0, failures = 0;
  int expAvg = 4, expSel = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  phase_align_rx i_phase_align_rx (
    .clk(clk), .rstN(rstN), .tapIn(tapIn), .slotStart(slotStart),
    .nodeAddr(nodeAddr), .selTap(selTap), .hdrWord(hdrWord),
    .hdrValid(hdrValid), .addrMatch(addrMatch)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int m8(int x);
    return ((x % 8) + 8) % 8;
  endfunction

  // taps 0..p carry the newer bit, the rest the older one; p=7 means no edge
  function automatic logic [7:0] edgeVec(int p, bit newB, bit oldB, bit bounce);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[k] = (k <= p) ? newB : oldB;
    if (bounce && p <= 5) v[p+2] = ~v[p+2];
    return v;
  endfunction

  // line bit n of a slot: preamble 1,0,1,0 then header MSB first, idle 0
  function automatic bit hb(int n, logic [15:0] h);
    if (n >= 0 && n <= 3) return (n % 2 == 0);
    if (n >= 4 && n <= 19) return h[19-n];
    return 1'b0;
  endfunction

  task automatic runSlot(int p0, int p1, int p2, int p3, bit bounce, logic [15:0] hdr);
    int pos[4];
    int refP, sum, d;
    bit lock;
    pos[0] = p0; pos[1] = p1; pos[2] = p2; pos[3] = p3;
    refP = -1; sum = 0;
    for (int i = 0; i < 4; i++) begin
      if (pos[i] < 7) begin
        if (refP < 0) refP = pos[i];
        else begin
          d = m8(pos[i] - refP);
          if (d >= 4) d -= 8;
          sum += d;
        end
      end
    end
    lock = (refP >= 0);
    if (lock) begin
      expAvg = m8(refP + (sum >>> 2));
      expSel = m8(expAvg + 4);
    end
    for (int n = 0; n <= 20; n++) begin
      @(negedge clk);
      if (n == 4) check(selTap == 3'(expSel), lock ? "R4" : "R5", "selTap", selTap, expSel);
      if (n >= 1) check(!hdrValid, "R6", "early hdrValid", hdrValid, 0);
      slotStart = (n == 0);
      if (n < 4) tapIn = edgeVec(pos[n], hb(n, hdr), hb(n - 1, hdr), bounce);
      else       tapIn = edgeVec(expAvg, hb(n, hdr), hb(n - 1, hdr), 1'b0);
    end
    @(negedge clk);
    slotStart = 1'b0;
    tapIn = '0;
    check(hdrValid == lock, lock ? "R6" : "R5", "hdrValid", hdrValid, lock);
    if (lock) check(hdrWord == hdr, "R6", "hdrWord", hdrWord, hdr);
    check(addrMatch == (lock && hdr[15:8] == nodeAddr), "R7", "addrMatch",
          addrMatch, lock && hdr[15:8] == nodeAddr);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!hdrValid && !addrMatch, "R9", "pulse after header", hdrValid, 0);
      if (lock) check(hdrWord == hdr, "R9", "hdrWord held", hdrWord, hdr);
      tapIn = (k == 0) ? 8'hA5 : (k == 1) ? 8'h3C : 8'h00;
    end
    @(negedge clk);
    check(!hdrValid, "R9", "quiet before next slot", hdrValid, 0);
  endtask

  task automatic abortSlot(logic [15:0] hdr);
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      if (n >= 1) check(!hdrValid, "R8", "abandoned hdrValid", hdrValid, 0);
      slotStart = (n == 0);
      tapIn = edgeVec((n < 4) ? 2 : 2, hb(n, hdr), hb(n - 1, hdr), 1'b0);
    end
    expAvg = 2; expSel = 6;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int jit [5][4];
    int hcount;
    jit[0] = '{0, 0, 0, 0};
    jit[1] = '{1, -1, 1, 0};
    jit[2] = '{2, 1, 2, 1};
    jit[3] = '{-1, -2, -1, -2};
    jit[4] = '{3, -3, 0, 1};
    repeat (3) @(negedge clk);
    check(selTap == 0 && hdrWord == 0 && !hdrValid && !addrMatch, "R1",
          "reset outputs", {selTap, hdrWord, hdrValid, addrMatch}, 0);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R6 R7: sweep base phase and jitter, bounce on odd runs
    hcount = 0;
    for (int b = 0; b < 8; b++) begin
      for (int j = 0; j < 5; j++) begin
        runSlot(m8(b + jit[j][0]), m8(b + jit[j][1]), m8(b + jit[j][2]), m8(b + jit[j][3]),
                hcount[0], {(hcount % 3 == 0) ? nodeAddr : nodeAddr ^ 8'h5A,
                            8'(hcount * 37 + 11)});
        hcount++;
      end
    end
    // R3 wrap across the tap range: 6,0,6,0 averages to 7
    runSlot(6, 0, 6, 0, 1'b0, {nodeAddr, 8'h96});
    check(expSel == 3, "R3", "wrap model", expSel, 3);
    // R3 missing edges contribute nothing: ref 3, one +1 step
    runSlot(7, 3, 7, 4, 1'b1, 16'h1234);
    // R5 no edge at all: tap kept, no valid
    runSlot(1, 1, 1, 1, 1'b0, {nodeAddr, 8'h01});
    runSlot(7, 7, 7, 7, 1'b0, {nodeAddr, 8'hFF});
    // R8 abandon a header part-way, then a full slot
    abortSlot(16'hC3C3);
    runSlot(5, 5, 4, 5, 1'b0, {nodeAddr, 8'h5A});
    runSlot(0, 0, 0, 1, 1'b1, 16'hFFFF);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule